// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Block Refill

This block is a read-only cache that sits between a processor load port and a word-wide main-memory port. It holds 2048 lines, and each line carries a valid flag, a 16-bit tag and a 32-byte block stored as eight 32-bit words. Every request address selects exactly one line. The stored tag is compared with the upper address bits. On a hit the block returns either a full 32-bit word or a single zero-extended byte, one cycle after it accepts the request.

On a miss the block reads the whole 32-byte block from memory, one word at a time, starting at word 0. Each word read is a valid/ready request followed by a response. Once the eighth word has arrived, the block overwrites the line unconditionally, marks it valid with the new tag and answers the pending request from the freshly filled data. Two free-running counters report how many accepted requests hit and how many missed.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0 and both counters read 0, so the first access to any line misses.
- R2: A request address is split as tag = bits [31:16], line index = bits [15:5], word = bits [4:2], byte = bits [1:0]; address 0x24 therefore uses line 1, word 1.
- R3: An accepted request (`req_valid` and `req_ready` at a clock edge) hits only when its line is valid and the stored tag equals the address tag; a hit raises `rsp_valid` for the cycle right after acceptance.
- R4: In word mode (`req_byte` = 0) `rsp_data` is the 32-bit word chosen by the word field of the address, and the byte field is ignored.
- R5: In byte mode (`req_byte` = 1) `rsp_data` is the byte chosen by the byte field, zero-extended, with byte 0 at word bits [7:0] (little-endian).
- R6: A miss issues exactly eight memory reads with addresses block_base + 4·k for k = 0..7 in increasing order. Only one read is outstanding at a time, and each address is held stable while `mem_req_ready` is 0.
- R7: While a refill is in progress `req_ready` stays 0. The response to the missing request appears the cycle after the eighth memory word arrives, and it carries the requested word or byte of the new block.
- R8: A refill replaces the block previously held in the line. Addresses 65536 bytes apart share a line, so alternating between them misses every time.
- R9: `hit_count` increments by one per accepted hit and `miss_count` by one per accepted miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | 32 | Byte address of the load |
| req_byte | input | 1 | 1 = return one byte, 0 = return a word |
| req_ready | output | 1 | Cache can accept a request this cycle |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 32 | Load data |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_addr | output | 32 | Word-aligned memory read address |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 32 | Memory read data |
| hit_count | output | 32 | Number of accepted hits |
| miss_count | output | 32 | Number of accepted misses |

## Verification
The bench keeps its own table of valid flags and tags, and it derives every memory word arithmetically from its address. A walk over all 2048 lines, with a different tag and word per line, separates correct index and tag slicing from swapped or truncated fields. All 32 word/byte combinations inside one line are then read back, which exposes errors in word order, byte order and zero extension. Alternating between addresses 64 KB apart, with occasional memory back-pressure, shows that a refill replaces the line, that refill reads arrive in order and that the hit and miss counts follow the model.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } dmc_state_e;
endpackage

// File: rtl/dmc_select.sv
module dmc_select #(
    parameter int DATA_W = 32,
    parameter int WORD_W = 3,
    parameter int BYTE_W = 2,
    localparam int LINE_W = DATA_W << WORD_W
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              byte_mode_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] word_sel;
    logic [7:0]        byte_sel;

    always_comb begin
        word_sel = line_i[int'(word_i)*DATA_W +: DATA_W];
        byte_sel = word_sel[int'(byte_i)*8 +: 8];
        data_o   = byte_mode_i ? {{(DATA_W-8){1'b0}}, byte_sel} : word_sel;
    end
endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
    parameter int TAG_W  = 16,
    parameter int IDX_W  = 11,
    parameter int LINE_W = 256,
    localparam int LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic              rd_valid_o,
    output logic [TAG_W-1:0]  rd_tag_o,
    output logic [LINE_W-1:0] rd_line_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [TAG_W-1:0]  wr_tag_i,
    input  logic [LINE_W-1:0] wr_line_i
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [LINE_W-1:0] line_mem [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en_i) begin
            valid_q[wr_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            tag_mem[wr_idx_i]  <= wr_tag_i;
            line_mem[wr_idx_i] <= wr_line_i;
        end
    end

    assign rd_valid_o = valid_q[rd_idx_i];
    assign rd_tag_o   = tag_mem[rd_idx_i];
    assign rd_line_o  = line_mem[rd_idx_i];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int IDX_W  = 11,
    parameter int WORD_W = 3,
    parameter int BYTE_W = 2,
    parameter int CNT_W  = 32,
    localparam int DATA_W   = 8 << BYTE_W,
    localparam int LINE_W   = DATA_W << WORD_W,
    localparam int OFF_WORD = BYTE_W,
    localparam int OFF_IDX  = BYTE_W + WORD_W,
    localparam int OFF_TAG  = OFF_IDX + IDX_W,
    localparam int ADDR_W   = OFF_TAG + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_byte,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    input  logic              look_valid_i,
    input  logic [TAG_W-1:0]  look_tag_i,
    input  logic [LINE_W-1:0] look_line_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [TAG_W-1:0]  wr_tag_o,
    output logic [LINE_W-1:0] wr_line_o
);
    typedef struct packed {
        dmc_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              bm;
        logic [WORD_W-1:0] cnt;
        logic [LINE_W-1:0] fill;
        logic              rsp_v;
        logic [DATA_W-1:0] rsp_d;
        logic [CNT_W-1:0]  hits;
        logic [CNT_W-1:0]  misses;
    } ctl_s;

    ctl_s q, d;
    logic [LINE_W-1:0] merged;
    logic [LINE_W-1:0] sel_line;
    logic [WORD_W-1:0] sel_word;
    logic [BYTE_W-1:0] sel_byte;
    logic              sel_bm;
    logic [DATA_W-1:0] sel_data;
    logic              is_hit;

    dmc_select #(.DATA_W(DATA_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_sel (
        .line_i(sel_line), .word_i(sel_word), .byte_i(sel_byte),
        .byte_mode_i(sel_bm), .data_o(sel_data)
    );

    always_comb begin
        merged = q.fill;
        merged[int'(q.cnt)*DATA_W +: DATA_W] = mem_rsp_data;
        if (q.st == ST_IDLE) begin
            sel_line = look_line_i;
            sel_word = req_addr[OFF_WORD +: WORD_W];
            sel_byte = req_addr[0 +: BYTE_W];
            sel_bm   = req_byte;
        end else begin
            sel_line = merged;
            sel_word = q.addr[OFF_WORD +: WORD_W];
            sel_byte = q.addr[0 +: BYTE_W];
            sel_bm   = q.bm;
        end
        is_hit = look_valid_i && (look_tag_i == req_addr[OFF_TAG +: TAG_W]);
    end

    always_comb begin
        d             = q;
        d.rsp_v       = 1'b0;
        req_ready     = (q.st == ST_IDLE);
        mem_req_valid = 1'b0;
        mem_req_addr  = {q.addr[ADDR_W-1:OFF_IDX], q.cnt, {BYTE_W{1'b0}}};
        wr_en_o       = 1'b0;
        wr_idx_o      = q.addr[OFF_IDX +: IDX_W];
        wr_tag_o      = q.addr[OFF_TAG +: TAG_W];
        wr_line_o     = merged;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.bm   = req_byte;
                    if (is_hit) begin
                        d.rsp_v = 1'b1;
                        d.rsp_d = sel_data;
                        d.hits  = q.hits + 1'b1;
                    end else begin
                        d.misses = q.misses + 1'b1;
                        d.cnt    = '0;
                        d.st     = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.fill = merged;
                    if (&q.cnt) begin
                        wr_en_o = 1'b1;
                        d.rsp_v = 1'b1;
                        d.rsp_d = sel_data;
                        d.st    = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                        d.st  = ST_ISSUE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid  = q.rsp_v;
    assign rsp_data   = q.rsp_d;
    assign hit_count  = q.hits;
    assign miss_count = q.misses;

    // R7: no new request is taken while a memory read is pending
    p_ready_low_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);
    // R6: a stalled read keeps its address
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R6: a single outstanding read
    p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
    // R9: counters advance by at most one
    p_hit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count - $past(hit_count)) <= 1);
    // R3: a response follows a request or a memory word
    p_rsp_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid) || $past(mem_rsp_valid)));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int TAG_W  = 16,
    parameter int IDX_W  = 11,
    parameter int WORD_W = 3,
    parameter int BYTE_W = 2,
    parameter int CNT_W  = 32,
    localparam int DATA_W  = 8 << BYTE_W,
    localparam int LINE_W  = DATA_W << WORD_W,
    localparam int OFF_IDX = BYTE_W + WORD_W,
    localparam int ADDR_W  = OFF_IDX + IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_byte,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    logic              look_valid;
    logic [TAG_W-1:0]  look_tag;
    logic [LINE_W-1:0] look_line;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [LINE_W-1:0] wr_line;

    dmc_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_i(req_addr[OFF_IDX +: IDX_W]),
        .rd_valid_o(look_valid), .rd_tag_o(look_tag), .rd_line_o(look_line),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag), .wr_line_i(wr_line)
    );

    dmc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W),
               .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_byte(req_byte),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .hit_count(hit_count), .miss_count(miss_count),
        .look_valid_i(look_valid), .look_tag_i(look_tag), .look_line_i(look_line),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_tag_o(wr_tag), .wr_line_o(wr_line)
    );
endmodule

// File: tb/dmc_cache_test.sv
module dmc_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_byte = 1'b0;
    logic        req_ready, rsp_valid, mem_req_valid;
    logic [31:0] rsp_data, mem_req_addr, hit_count, miss_count;
    logic        mem_req_ready;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int exp_hits = 0;
    int exp_miss = 0;
    bit stall_en = 1'b0;
    logic [1:0]  stall_ctr = '0;
    int          hs_count = 0;
    logic [31:0] exp_base = '0;
    bit          mdl_valid [2048];
    logic [15:0] mdl_tag   [2048];

    always #5 clk = ~clk;

    dmc_cache uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_byte(req_byte), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return ({2'b00, a[31:2]} * 32'h9E37_79B1) + 32'h0123_4567;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // memory model: one-cycle response, optional back-pressure
    assign mem_req_ready = !stall_en || (stall_ctr != 2'd0);
    always @(posedge clk) begin
        stall_ctr     <= stall_ctr + 2'd1;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            // R6: ascending word addresses within the block
            chk(mem_req_addr == exp_base + 32'(4 * (hs_count % 8)), "R6 fill address",
                mem_req_addr, exp_base + 32'(4 * (hs_count % 8)));
            hs_count      <= hs_count + 1;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= memf(mem_req_addr);
        end
    end

    task automatic access(input logic [31:0] a, input bit bm, input string rq);
        int          lat;
        bit          exp_hit;
        bit          ready_ok;
        logic [31:0] w, e;
        logic [10:0] idx;
        idx     = a[15:5];
        exp_hit = mdl_valid[idx] && (mdl_tag[idx] == a[31:16]);
        w       = memf({a[31:2], 2'b00});
        e       = bm ? ((w >> (8 * a[1:0])) & 32'hFF) : w;
        exp_base = {a[31:5], 5'b0};
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_byte  = bm;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        ready_ok = 1'b1;
        while (!rsp_valid && lat < 200) begin
            if (req_ready) ready_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (exp_hit) begin
            exp_hits++;
            chk(lat == 1, {rq, " R3 hit latency"}, 32'(lat), 32'd1);
        end else begin
            exp_miss++;
            chk(lat > 1 && ready_ok, {rq, " R7 miss refill, ready low"}, 32'(lat), 32'd17);
        end
        chk(rsp_data == e, {rq, " data"}, rsp_data, e);
        mdl_valid[idx] = 1'b1;
        mdl_tag[idx]   = a[31:16];
    endtask

    task automatic counters(input string rq);
        @(negedge clk);
        chk(hit_count == 32'(exp_hits), {rq, " R9 hit_count"}, hit_count, 32'(exp_hits));
        chk(miss_count == 32'(exp_miss), {rq, " R9 miss_count"}, miss_count, 32'(exp_miss));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mdl_valid[i] = 1'b0;
            mdl_tag[i]   = '0;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
            {29'b0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
        chk(hit_count == 0 && miss_count == 0, "R1 reset counters", hit_count | miss_count, 0);

        // R2: 0x24 is line 1 word 1; first access misses (R1)
        access(32'h0000_0024, 1'b0, "R2 R1 first access 0x24");
        access(32'h0000_0024, 1'b0, "R2 re-read 0x24");
        access(32'h0000_0004, 1'b0, "R2 line 0 distinct from line 1");
        counters("R2 after 0x24");

        // R4/R5: all words and bytes of line 1 (byte field ignored in word mode)
        for (int wd = 0; wd < 8; wd++)
            for (int by = 0; by < 4; by++) begin
                access(32'h20 + 32'(wd * 4 + by), 1'b0, "R4 word select");
                access(32'h20 + 32'(wd * 4 + by), 1'b1, "R5 byte select");
            end
        counters("R4 R5 sweep");

        // R8: 64 KB aliasing, with back-pressure on memory (R6)
        stall_en = 1'b1;
        access(32'h0001_0024, 1'b0, "R8 alias +64K");
        access(32'h0000_0024, 1'b1, "R8 alias back");
        access(32'h0001_0024, 1'b0, "R8 alias again");
        access(32'h0001_003F, 1'b1, "R8 alias resident hit");
        access(32'hFFFF_0020, 1'b0, "R8 top tag");
        access(32'hFFFF_003C, 1'b0, "R8 top tag hit");
        stall_en = 1'b0;
        counters("R8 aliasing");

        // R2/R3: every line, varied tag and word
        for (int i = 0; i < 2048; i++)
            access({16'(i * 7 + 3), 11'(i), 3'(i), 2'b00}, 1'b0, "R3 line sweep miss");
        for (int i = 0; i < 2048; i += 5)
            access({16'(i * 7 + 3), 11'(i), 3'(i + 1), 2'(i)}, 1'b1, "R3 line sweep hit");
        for (int i = 0; i < 64; i++)
            access({16'(i * 7 + 4), 11'(i), 3'(i), 2'b00}, 1'b0, "R3 tag mismatch");
        counters("R9 final");
        finish_run();
    end
endmodule